// File: doc/BRIEF.md
# Two-Port Shared Memory with Collision Arbitration and Mailbox Flags

This block is a 1024-word by 8-bit memory with two independent clocked ports, called left and right. Each port has its own enable, write select, output enable, address and data buses. Either port can read or write any word.

When both ports touch the same word in the same cycle and at least one of them writes, an arbiter lets the left port through. It drops the right port's write and flags the right port as busy.

The two highest words serve as mailboxes. A write by one port into the other port's mailbox word raises the other port's interrupt flag. That flag falls again when the owning port reads its own mailbox word.

A mode input changes an instance into a slave. In slave mode the internal arbiter is switched off, and per-port busy inputs, driven by a master instance, gate the writes. Several instances can then be placed side by side to build wider words.

Top module: `dpr_mailbox_ram`

## Requirements
- R1: Each of the 1024 words, at addresses 0 to 1023, can be written by one port and then read back with the same value by the other port.
- R2: A read is a cycle with enable=1 and write=0. When output enable is also 1, the data appears on that port's read bus after the next rising edge. The data is the word's contents before any write made in that same cycle.
- R3: Both ports may read the same word in the same cycle. Both receive its value and neither busy flag rises.
- R4: After a cycle in which a port had enable=0, output enable=0 or write=1, that port's read bus is zero. A port with enable=0 writes nothing.
- R5: The master case is mode=0, with both ports enabled on the same address and at least one writing. The left access takes effect and the right write is dropped. The right busy output is 1 for the following cycle. The left busy output stays 0, and accesses to different addresses never raise busy.
- R6: An effective right-port write to address 1023 sets the left interrupt flag after the edge. A left-port read of address 1023 clears it.
- R7: An effective left-port write to address 1022 sets the right interrupt flag, and a right-port read of address 1022 clears it. If the set and the clear fall in the same cycle, the flag ends up set.
- R8: In slave mode (mode=1), both busy outputs are 0 and no internal arbitration takes place. A port's write is dropped while that port's busy input is 1. Reads are not affected.
- R9: While reset is active (active-low, asynchronous) and after it is released, both interrupt flags, both busy outputs and both read buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = busy taken from inputs, 0 = internal arbitration |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write select |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | 10 | Left port address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port read data |
| l_busy_i | input | 1 | Left busy input (slave mode) |
| l_busy_o | output | 1 | Left busy flag (master mode) |
| l_irq | output | 1 | Left mailbox interrupt |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write select |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | 10 | Right port address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port read data |
| r_busy_i | input | 1 | Right busy input (slave mode) |
| r_busy_o | output | 1 | Right busy flag (master mode) |
| r_irq | output | 1 | Right mailbox interrupt |

## Verification
Collision arbitration and the mailbox flags can act in the same cycle. In one test the left port writes the right mailbox word while the right port reads it. In another the right port writes the left mailbox word while the left port reads it. The bench judges the result from the flag, the busy output and the read data one edge later, using a reference array. It also sweeps all addresses in both directions and with same-word reads.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;

  // mailbox word owned by a side: left owns the top word, right the one below
  function automatic int unsigned box_addr(input side_e side, input int unsigned aw);
    int unsigned top;
    top = (1 << aw) - 1;
    return (side == SIDE_LEFT) ? top : top - 1;
  endfunction
endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dpr_mem.sv
module dpr_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_word,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] l_word_q;
  logic [DATA_W-1:0] r_word_q;

  // writes: right first, left last so that the left port prevails on a tie
  always_ff @(posedge clk) begin
    if (r_wr) store[r_addr] <= r_wdata;
    if (l_wr) store[l_addr] <= l_wdata;
  end

  // registered reads with clock enable, read-before-write
  always_ff @(posedge clk) begin
    if (l_rd) l_word_q <= store[l_addr];
    if (r_rd) r_word_q <= store[r_addr];
  end

  assign l_word = l_word_q;
  assign r_word = r_word_q;
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_i,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_i,
  output logic              l_wr_ok,
  output logic              r_wr_ok,
  output logic              l_busy_o,
  output logic              r_busy_o
);
  logic clash;
  logic l_busy_d, r_busy_d;
  logic l_busy_q, r_busy_q;

  assign clash = l_en && r_en && (l_addr == r_addr) && (l_we || r_we);

  always_comb begin
    if (slave_mode) begin
      l_wr_ok  = l_en && l_we && !l_busy_i;
      r_wr_ok  = r_en && r_we && !r_busy_i;
      l_busy_d = 1'b0;
      r_busy_d = 1'b0;
    end else begin
      l_wr_ok  = l_en && l_we;
      r_wr_ok  = r_en && r_we && !clash;
      l_busy_d = 1'b0;
      r_busy_d = clash;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_busy_q <= 1'b0;
      r_busy_q <= 1'b0;
    end else begin
      l_busy_q <= l_busy_d;
      r_busy_q <= r_busy_d;
    end
  end

  assign l_busy_o = l_busy_q;
  assign r_busy_o = r_busy_q;

  assert_clash_right_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && l_en && r_en && l_addr == r_addr && (l_we || r_we))
      |=> (r_busy_o && !l_busy_o));

  assert_clash_drops_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && l_en && r_en && l_addr == r_addr && r_we) |-> !r_wr_ok);

  assert_slave_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && (l_busy_i || r_busy_i)) |-> !((l_busy_i && l_wr_ok) || (r_busy_i && r_wr_ok)));

  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |=> (!l_busy_o && !r_busy_o));
endmodule

// File: rtl/dpr_mailbox.sv
module dpr_mailbox
  import dpr_pkg::*;
#(
  parameter int    ADDR_W = 10,
  parameter side_e SIDE   = SIDE_LEFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_rd,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              peer_wr,
  input  logic [ADDR_W-1:0] peer_addr,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] BOX = ADDR_W'(box_addr(SIDE, ADDR_W));

  logic hit_set, hit_clr;
  logic irq_d, irq_q;

  assign hit_set = peer_wr && (peer_addr == BOX);
  assign hit_clr = own_rd && (own_addr == BOX);

  // a new message outranks the acknowledge of the old one
  always_comb begin
    irq_d = irq_q;
    if (hit_clr) irq_d = 1'b0;
    if (hit_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  assert_mbox_set_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_wr && peer_addr == BOX) |=> irq);

  assert_mbox_clear_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_rd && own_addr == BOX && !(peer_wr && peer_addr == BOX)) |=> !irq);

  assert_mbox_hold_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(own_rd && own_addr == BOX) && !(peer_wr && peer_addr == BOX)) |=> $stable(irq));
endmodule

// File: rtl/dpr_mailbox_ram.sv
module dpr_mailbox_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              l_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  output logic              l_irq,
  input  logic              r_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_i,
  output logic              r_busy_o,
  output logic              r_irq
);
  logic rst_i_n;
  logic l_wr_ok, r_wr_ok;
  logic l_rd, r_rd;
  logic l_show_d, r_show_d;
  logic l_show_q, r_show_q;
  logic [DATA_W-1:0] l_word, r_word;

  dpr_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign l_rd = l_en && !l_we;
  assign r_rd = r_en && !r_we;

  dpr_arbiter #(.ADDR_W(ADDR_W)) i_arb (
    .clk(clk), .rst_n(rst_i_n), .slave_mode(slave_mode),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_busy_i(l_busy_i),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_busy_i(r_busy_i),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok),
    .l_busy_o(l_busy_o), .r_busy_o(r_busy_o)
  );

  dpr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk(clk),
    .l_wr(l_wr_ok), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata), .l_word(l_word),
    .r_wr(r_wr_ok), .r_rd(r_rd), .r_addr(r_addr), .r_wdata(r_wdata), .r_word(r_word)
  );

  dpr_mailbox #(.ADDR_W(ADDR_W), .SIDE(SIDE_LEFT)) i_box_l (
    .clk(clk), .rst_n(rst_i_n),
    .own_rd(l_rd), .own_addr(l_addr),
    .peer_wr(r_wr_ok), .peer_addr(r_addr),
    .irq(l_irq)
  );

  dpr_mailbox #(.ADDR_W(ADDR_W), .SIDE(SIDE_RIGHT)) i_box_r (
    .clk(clk), .rst_n(rst_i_n),
    .own_rd(r_rd), .own_addr(r_addr),
    .peer_wr(l_wr_ok), .peer_addr(l_addr),
    .irq(r_irq)
  );

  // output gating: show the word only after a read with output enable
  always_comb begin
    l_show_d = l_rd && l_oe;
    r_show_d = r_rd && r_oe;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      l_show_q <= 1'b0;
      r_show_q <= 1'b0;
    end else begin
      l_show_q <= l_show_d;
      r_show_q <= r_show_d;
    end
  end

  assign l_rdata = l_show_q ? l_word : '0;
  assign r_rdata = r_show_q ? r_word : '0;

  assert_left_quiet_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!l_en || l_we || !l_oe) |=> (l_rdata == '0));

  assert_right_quiet_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!r_en || r_we || !r_oe) |=> (r_rdata == '0));

  assert_shared_read_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (l_en && r_en && !l_we && !r_we && l_oe && r_oe && l_addr == r_addr)
      |=> (l_rdata == r_rdata));

  assert_idle_no_write_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    !l_en |-> !l_wr_ok);
endmodule

// File: tb/test_dpr_mailbox_ram.sv
module test_dpr_mailbox_ram;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam logic [AW-1:0] LBOX = AW'(N - 1);
  localparam logic [AW-1:0] RBOX = AW'(N - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic l_en = 0, l_we = 0, l_oe = 1, l_busy_i = 0;
  logic r_en = 0, r_we = 0, r_oe = 1, r_busy_i = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_o, r_busy_o, l_irq, r_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [DW-1:0] model [N];

  always #10 clk = ~clk;

  dpr_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_mailbox_ram (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o), .l_irq(l_irq),
    .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o), .r_irq(r_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    l_en = 0; l_we = 0; l_oe = 1; l_busy_i = 0;
    r_en = 0; r_we = 0; r_oe = 1; r_busy_i = 0;
  endtask

  task automatic lwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_en = 1; l_we = 1; l_addr = a; l_wdata = d;
  endtask
  task automatic rwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_en = 1; r_we = 1; r_addr = a; r_wdata = d;
  endtask
  task automatic lrd(input logic [AW-1:0] a);
    l_en = 1; l_we = 0; l_oe = 1; l_addr = a;
  endtask
  task automatic rrd(input logic [AW-1:0] a);
    r_en = 1; r_we = 0; r_oe = 1; r_addr = a;
  endtask

  function automatic logic [DW-1:0] pat_a(input int a);
    return DW'((a * 37 + 11) ^ (a >> 3));
  endfunction
  function automatic logic [DW-1:0] pat_b(input int a);
    return DW'(~(a * 13 + 5));
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // reset phase
    repeat (3) step();
    chk("R9 l_irq in reset", l_irq, 0);
    chk("R9 r_irq in reset", r_irq, 0);
    chk("R9 busy in reset", {l_busy_o, r_busy_o}, 0);
    chk("R9 rdata in reset", {l_rdata, r_rdata}, 0);
    rst_n = 1;
    repeat (3) step();
    chk("R9 flags after release", {l_irq, r_irq, l_busy_o, r_busy_o}, 0);

    // sweep: left writes everything, right reads back
    for (int a = 0; a < N; a++) begin
      idle(); lwr(AW'(a), pat_a(a)); model[a] = pat_a(a);
      step();
      if (a == 0) chk("R4 rdata after write", l_rdata, 0);
    end
    idle(); step();
    chk("R7 right flag set by sweep", r_irq, 1);
    chk("R6 left flag untouched", l_irq, 0);
    for (int a = 0; a < N; a++) begin
      idle(); rrd(AW'(a)); step();
      chk("R1 right reads left data", r_rdata, model[a]);
    end
    idle(); step();
    chk("R7 right flag cleared by read", r_irq, 0);

    // sweep: right writes everything, left reads back
    for (int a = 0; a < N; a++) begin
      idle(); rwr(AW'(a), pat_b(a)); model[a] = pat_b(a); step();
    end
    idle(); step();
    chk("R6 left flag set by sweep", l_irq, 1);
    for (int a = 0; a < N; a++) begin
      idle(); lrd(AW'(a)); step();
      chk("R1 left reads right data", l_rdata, model[a]);
    end
    idle(); step();
    chk("R6 left flag cleared by read", l_irq, 0);

    // sweep: both read the same word
    for (int a = 0; a < N; a++) begin
      idle(); lrd(AW'(a)); rrd(AW'(a)); step();
      chk("R3 left shared read", l_rdata, model[a]);
      chk("R3 right shared read", r_rdata, model[a]);
      chk("R3 no busy", {l_busy_o, r_busy_o}, 0);
    end

    // write-write collision: left wins
    idle(); lwr(10'h155, 8'hA1); rwr(10'h155, 8'h5E); step();
    model[10'h155] = 8'hA1;
    chk("R5 right busy on clash", r_busy_o, 1);
    chk("R5 left never busy", l_busy_o, 0);
    idle(); step();
    chk("R5 busy lasts one cycle", r_busy_o, 0);
    lrd(10'h155); step();
    chk("R5 left value kept", l_rdata, 8'hA1);

    // left write / right read collision: read-before-write
    idle(); lwr(10'h155, 8'hC3); rrd(10'h155); step();
    chk("R2 right sees old word", r_rdata, 8'hA1);
    chk("R5 busy on write-read clash", r_busy_o, 1);
    model[10'h155] = 8'hC3;

    // right write / left read collision: right write dropped
    idle(); rwr(10'h155, 8'h0F); lrd(10'h155); step();
    chk("R2 left sees current word", l_rdata, 8'hC3);
    chk("R5 busy on read-write clash", r_busy_o, 1);
    idle(); rrd(10'h155); step();
    chk("R5 right write dropped", r_rdata, 8'hC3);

    // different addresses never clash
    idle(); lwr(10'h020, 8'h11); rwr(10'h021, 8'h22); step();
    chk("R5 no busy on distinct words", {l_busy_o, r_busy_o}, 0);
    idle(); lrd(10'h021); rrd(10'h020); step();
    chk("R1 right write landed", l_rdata, 8'h22);
    chk("R1 left write landed", r_rdata, 8'h11);

    // left mailbox
    idle(); rwr(LBOX, 8'hA5); step();
    chk("R6 left flag set", l_irq, 1);
    chk("R7 right flag stays low", r_irq, 0);
    idle(); lrd(LBOX); step();
    chk("R6 left reads message", l_rdata, 8'hA5);
    chk("R6 left flag cleared", l_irq, 0);
    idle(); lrd(LBOX); rwr(LBOX, 8'h99); step();
    chk("R6 suppressed write sets nothing", l_irq, 0);
    chk("R5 busy on mailbox clash", r_busy_o, 1);
    idle(); lrd(LBOX); step();
    chk("R6 mailbox word unchanged", l_rdata, 8'hA5);

    // right mailbox, including set and clear in the same cycle
    idle(); lwr(RBOX, 8'h3C); step();
    chk("R7 right flag set", r_irq, 1);
    idle(); rrd(RBOX); step();
    chk("R7 right reads message", r_rdata, 8'h3C);
    chk("R7 right flag cleared", r_irq, 0);
    idle(); lwr(RBOX, 8'h77); rrd(RBOX); step();
    chk("R7 set wins over clear", r_irq, 1);
    chk("R7 right sees old message", r_rdata, 8'h3C);
    chk("R5 busy with mailbox traffic", r_busy_o, 1);
    idle(); rrd(RBOX); step();
    chk("R7 new message", r_rdata, 8'h77);
    chk("R7 cleared afterwards", r_irq, 0);

    // disabled port and output enable
    idle(); l_en = 0; l_we = 1; l_addr = 10'h005; l_wdata = ~model[5]; step();
    chk("R4 disabled port rdata", l_rdata, 0);
    idle(); l_en = 1; l_we = 0; l_oe = 0; l_addr = 10'h005; step();
    chk("R4 output enable low", l_rdata, 0);
    idle(); rrd(10'h005); step();
    chk("R4 disabled port wrote nothing", r_rdata, model[5]);

    // slave mode
    slave_mode = 1;
    idle(); r_busy_i = 1; rwr(10'h007, ~model[7]); step();
    chk("R8 busy outputs low", {l_busy_o, r_busy_o}, 0);
    idle(); lrd(10'h007); step();
    chk("R8 gated right write dropped", l_rdata, model[7]);
    idle(); l_busy_i = 1; lwr(10'h009, 8'hEE); rwr(10'h009, 8'h44); step();
    model[9] = 8'h44;
    chk("R8 no internal arbitration", {l_busy_o, r_busy_o}, 0);
    idle(); l_busy_i = 1; lrd(10'h009); step();
    chk("R8 read unaffected, right write kept", l_rdata, 8'h44);
    idle(); r_busy_i = 1; rwr(LBOX, 8'h12); step();
    chk("R8 gated mailbox write sets nothing", l_irq, 0);
    slave_mode = 0;

    // reset mid-run clears flags
    idle(); rwr(LBOX, 8'h34); lwr(RBOX, 8'h56); step();
    chk("R6 flag before reset", l_irq, 1);
    chk("R7 flag before reset", r_irq, 1);
    idle(); lrd(10'h009); rst_n = 0; step();
    chk("R9 flags cleared by reset", {l_irq, r_irq, l_busy_o, r_busy_o}, 0);
    chk("R9 rdata cleared by reset", l_rdata, 0);
    idle(); rst_n = 1; repeat (3) step();
    chk("R9 flags low after second release", {l_irq, r_irq}, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule